// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt lines and a processor core. It picks which line the core serves next, and it tells the core when to enter a handler. Every line has three programmable settings: an enable, a pending flag and an 8-bit urgency, where 0 is the most urgent. A write port loads these settings along with one handler address per line. When a line is eligible, the controller raises an entry request. With that request it gives the line number and the line's handler address. The core accepts the request with a one-cycle acknowledge and reports the end of a handler with a return strobe.

The controller keeps a stack of the urgencies of the handlers currently running. A request that is strictly more urgent than the top of the stack preempts the running handler, so handlers nest. A handler can end while another line is already eligible. In that case the next request follows at once and carries a tail-chain flag, so the core can go straight to the new handler without restoring the interrupted context first. A global mask input holds off every new entry.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `entry_req` and `tail_chain` are low and no handler is active.
- R2: Among lines that are both pending and enabled, the line with the numerically lowest urgency wins. When urgencies are equal, the lowest line index wins.
- R3: While a handler runs, a request is raised only for a line whose urgency is strictly lower in value than the running urgency. A line with equal urgency waits.
- R4: A line's pending flag sets on a rising edge of `irq_in`. It stays set until that line's request is acknowledged. A write with kind 3 sets the flag of line `wr_idx` and a write with kind 4 clears it. An acknowledge or a clear takes effect over a set in the same cycle.
- R5: `entry_addr` is the handler address of the line on `entry_src`. A write with kind 2 loads that address from `wr_data`.
- R6: Once a return strobe is accepted, an eligible line found in the following cycle raises its request one clock later with `tail_chain` high. The flag stays high for as long as that request is held.
- R7: `entry_req` rises one clock after the cycle in which a line becomes eligible. After an accepted acknowledge or an accepted return, `entry_req` is low for at least one cycle. An acknowledge counts only while `entry_req` is high.
- R8: A line is eligible only when its enable is set. A write with kind 1 loads the enable from `wr_data[0]`. While a line is disabled its pending flag is kept.
- R9: While `mask_all` is high, no new request is raised.
- R10: The stack holds 8 levels. When 8 handlers are active, no request is raised until a return frees a level.
- R11: An accepted acknowledge pushes the line's urgency onto the stack. A return pops the stack, so the running urgency reverts to the level below, or to idle. A return while idle is ignored and does not cause a tail chain.
- R12: A write with kind 0 loads the line's urgency from `wr_data[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt lines, edge-detected |
| mask_all | input | 1 | Holds off all new entries |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 3 | 0 urgency, 1 enable, 2 handler address, 3 set pending, 4 clear pending |
| wr_idx | input | IDX_W | Line addressed by the write |
| wr_data | input | ADDR_W | Write data |
| entry_req | output | 1 | Request to enter a handler |
| entry_src | output | IDX_W | Line selected for entry |
| entry_addr | output | ADDR_W | Handler address of the selected line |
| tail_chain | output | 1 | Entry follows a return directly |
| entry_ack | input | 1 | Core accepts the request |
| handler_ret | input | 1 | Core has finished the current handler |

## Verification
The bench goes after several corner cases, and each has a failure signature:
- Equal urgency. A controller that compared with less-or-equal would preempt a running handler with an equal-urgency line, and it would pick the higher line index in a tie.
- Return handling. A return that did not pop, or a tail flag taken from the wrong cycle, would show up as a missing or unflagged request right after a handler returns. It would also show up as a spurious chain after a return made while idle.
- Stack limit. The ninth nested entry must wait for a free level. A design that let it through would overflow the stack.
- Blocking. A design that ignored `mask_all` or a disable would raise a request while blocked. A design that dropped the pending flag while blocked would never raise one once the block lifted.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [2:0] {
    WR_URGENCY = 3'd0,
    WR_ENABLE  = 3'd1,
    WR_VECTOR  = 3'd2,
    WR_SETPEND = 3'd3,
    WR_CLRPEND = 3'd4
  } wr_kind_e;

  // candidate beats incumbent only when strictly more urgent (lower value)
  function automatic logic more_urgent(input int unsigned cand, input int unsigned incumbent);
    return cand < incumbent;
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] set_vec,
  input  logic [N_SRC-1:0] clr_vec,
  output logic [N_SRC-1:0] pend
);

  logic [N_SRC-1:0] irq_q;
  logic [N_SRC-1:0] rise;

  assign rise = irq_in & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      pend  <= '0;
    end else begin
      irq_q <= irq_in;
      pend  <= (pend | rise | set_vec) & ~clr_vec;
    end
  end

  // R4: a cleared or acknowledged line is not pending in the next cycle
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((pend & $past(clr_vec)) == '0));

  // R4: a pending flag never drops without a clear
  a_r4_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> ((pend | $past(clr_vec)) & $past(pend)) == $past(pend));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_ctrl_pkg::*; #(
  parameter int N_SRC  = 32,
  parameter int PRIO_W = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]             cand,
  input  logic [N_SRC-1:0][PRIO_W-1:0] urg,
  output logic                         win_any,
  output logic [IDX_W-1:0]             win_idx,
  output logic [PRIO_W-1:0]            win_prio
);

  // ascending scan with strict compare: ties stay with the lowest index
  always_comb begin
    win_any  = 1'b0;
    win_idx  = '0;
    win_prio = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (cand[i] && (!win_any || more_urgent(int'(urg[i]), int'(win_prio)))) begin
        win_any  = 1'b1;
        win_idx  = IDX_W'(i);
        win_prio = urg[i];
      end
    end
  end

  // R2: no candidate is more urgent, or equally urgent at a lower index
  always_comb begin
    if (win_any) begin
      for (int i = 0; i < N_SRC; i++) begin
        a_r2_no_better: assert (!(cand[i] && ((urg[i] < win_prio) ||
                                 (urg[i] == win_prio && i < int'(win_idx)))));
      end
    end
  end

endmodule

// File: rtl/irq_active_stack.sv
module irq_active_stack #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 8,
  localparam int DW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_prio,
  output logic [DW-1:0]     depth,
  output logic [PRIO_W-1:0] top_prio,
  output logic              empty,
  output logic              full
);

  logic [DEPTH-1:0][PRIO_W-1:0] mem;
  logic [AW-1:0]                top_slot;
  logic [AW-1:0]                next_slot;

  assign empty     = (depth == '0);
  assign full      = (depth == DW'(DEPTH));
  assign top_slot  = AW'(depth - 1'b1);
  assign next_slot = AW'(depth);
  assign top_prio  = empty ? '1 : mem[top_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth <= '0;
      mem   <= '0;
    end else if (push && pop) begin
      mem[top_slot] <= push_prio;
    end else if (push) begin
      mem[next_slot] <= push_prio;
      depth          <= depth + 1'b1;
    end else if (pop) begin
      depth <= depth - 1'b1;
    end
  end

  // R10: the stack never holds more than DEPTH levels
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));

  // R10: nobody pushes onto a full stack
  a_r10_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |-> !push);

  // R11: a push makes its urgency the running one
  a_r11_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (top_prio == $past(push_prio)));

  // R11: a return drops exactly one level
  a_r11_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (depth == $past(depth) - 1'b1));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import irq_ctrl_pkg::*; #(
  parameter int N_SRC       = 32,
  parameter int PRIO_W      = 8,
  parameter int ADDR_W      = 32,
  parameter int STACK_DEPTH = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int DW    = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              mask_all,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  output logic              entry_req,
  output logic [IDX_W-1:0]  entry_src,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              tail_chain,
  input  logic              entry_ack,
  input  logic              handler_ret
);

  logic [N_SRC-1:0][PRIO_W-1:0] urg_tab;
  logic [N_SRC-1:0]             en_tab;
  logic [N_SRC-1:0][ADDR_W-1:0] vec_tab;

  logic [N_SRC-1:0] pend, set_vec, clr_vec, idx_hot;
  logic             wr_ok;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic [DW-1:0]    stk_depth;
  logic [PRIO_W-1:0] top_prio;
  logic             stk_empty, stk_full;

  // named internal events
  logic ack_fire, ret_fire, eligible, next_req;

  logic [PRIO_W-1:0] entry_prio_q;
  logic              ret_seen;

  assign wr_ok   = wr_en && (int'(wr_idx) < N_SRC);
  assign idx_hot = N_SRC'(1) << wr_idx;
  assign set_vec = (wr_ok && wr_kind == WR_SETPEND) ? idx_hot : '0;
  assign clr_vec = ((wr_ok && wr_kind == WR_CLRPEND) ? idx_hot : '0) |
                   (ack_fire ? (N_SRC'(1) << entry_src) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      urg_tab <= '0;
      en_tab  <= '0;
      vec_tab <= '0;
    end else if (wr_ok) begin
      case (wr_kind)
        WR_URGENCY: urg_tab[wr_idx] <= wr_data[PRIO_W-1:0];
        WR_ENABLE:  en_tab[wr_idx]  <= wr_data[0];
        WR_VECTOR:  vec_tab[wr_idx] <= wr_data;
        default: ;
      endcase
    end
  end

  irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .set_vec(set_vec), .clr_vec(clr_vec), .pend(pend)
  );

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .cand(pend & en_tab), .urg(urg_tab),
    .win_any(win_any), .win_idx(win_idx), .win_prio(win_prio)
  );

  irq_active_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(ack_fire), .pop(ret_fire),
    .push_prio(entry_prio_q), .depth(stk_depth), .top_prio(top_prio),
    .empty(stk_empty), .full(stk_full)
  );

  assign ack_fire = entry_ack && entry_req;
  assign ret_fire = handler_ret && !stk_empty;
  assign eligible = win_any && !mask_all && !stk_full &&
                    (stk_empty || more_urgent(int'(win_prio), int'(top_prio)));
  // state moves on ack or return: hold the request off for one evaluation
  assign next_req = eligible && !ack_fire && !ret_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_req    <= 1'b0;
      entry_src    <= '0;
      entry_addr   <= '0;
      entry_prio_q <= '0;
      tail_chain   <= 1'b0;
      ret_seen     <= 1'b0;
    end else begin
      entry_req    <= next_req;
      entry_src    <= win_idx;
      entry_addr   <= vec_tab[win_idx];
      entry_prio_q <= win_prio;
      tail_chain   <= next_req && (ret_seen || tail_chain);
      ret_seen     <= ret_fire;
    end
  end

  // R3: a raised request always outranks the running handler
  a_r3_req_outranks: assert property (@(posedge clk) disable iff (!rst_n)
    entry_req |-> (stk_empty || entry_prio_q < top_prio));

  // R7: an accepted acknowledge drops the request for a cycle
  a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !entry_req);

  // R9: the global mask blocks the next request
  a_r9_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask_all |=> !entry_req);

  // R6: the tail-chain flag travels only with a request
  a_r6_tail_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    tail_chain |-> entry_req);

  // R10: a full stack raises no request
  a_r10_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |=> !entry_req);

  // R11: entering a handler deepens the nesting by one
  a_r11_ack_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !ret_fire) |=> (stk_depth == $past(stk_depth) + 1'b1));

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        mask_all = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_kind = '0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        entry_ack = 1'b0;
  logic        handler_ret = 1'b0;
  logic        entry_req, tail_chain;
  logic [4:0]  entry_src;
  logic [31:0] entry_addr;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .mask_all(mask_all),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
    .entry_req(entry_req), .entry_src(entry_src), .entry_addr(entry_addr),
    .tail_chain(tail_chain), .entry_ack(entry_ack), .handler_ret(handler_ret)
  );

  // ---------------- behavioural reference model ----------------
  int          m_urg[N];
  bit          m_en[N];
  logic [31:0] m_vec[N];
  bit          m_pend[N];
  bit          m_irqq[N];
  int          m_stk[$];
  bit          m_req, m_tail, m_retseen;
  int          m_src, m_cprio;
  logic [31:0] m_caddr;
  int          best;
  bit          elig, fire, retf, nreq;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_urg[i] = 0; m_en[i] = 0; m_vec[i] = 0; m_pend[i] = 0; m_irqq[i] = 0;
      end
      m_stk.delete();
      m_req = 0; m_tail = 0; m_retseen = 0; m_src = 0; m_cprio = 0; m_caddr = 0;
    end else begin
      best = -1;
      for (int i = 0; i < N; i++)
        if (m_pend[i] && m_en[i] && (best < 0 || m_urg[i] < m_urg[best])) best = i;
      elig = (best >= 0) && !mask_all && (m_stk.size() < DEPTH) &&
             (m_stk.size() == 0 || m_urg[(best < 0) ? 0 : best] < m_stk[m_stk.size()-1]);
      fire = entry_ack && m_req;
      retf = handler_ret && (m_stk.size() > 0);
      nreq = elig && !fire && !retf;
      for (int i = 0; i < N; i++) begin
        if (irq[i] && !m_irqq[i]) m_pend[i] = 1;
        m_irqq[i] = irq[i];
        if (wr_en && wr_kind == 3 && int'(wr_idx) == i) m_pend[i] = 1;
        if (wr_en && wr_kind == 4 && int'(wr_idx) == i) m_pend[i] = 0;
        if (fire && m_src == i) m_pend[i] = 0;
      end
      if (retf) void'(m_stk.pop_back());
      if (fire) m_stk.push_back(m_cprio);
      m_tail = nreq && (m_retseen || m_tail);
      m_retseen = retf;
      m_req = nreq;
      if (best >= 0) begin
        m_src = best; m_cprio = m_urg[best]; m_caddr = m_vec[best];
      end
      if (wr_en) begin
        case (wr_kind)
          3'd0: m_urg[wr_idx] = int'(wr_data[7:0]);
          3'd1: m_en[wr_idx]  = wr_data[0];
          3'd2: m_vec[wr_idx] = wr_data;
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (entry_req !== m_req) begin
        fails++; $display("FAIL R7 model entry_req actual=%0b expected=%0b", entry_req, m_req);
      end
      if (tail_chain !== m_tail) begin
        fails++; $display("FAIL R6 model tail_chain actual=%0b expected=%0b", tail_chain, m_tail);
      end
      if (m_req && entry_src !== 5'(m_src)) begin
        fails++; $display("FAIL R2 model entry_src actual=%0d expected=%0d", entry_src, m_src);
      end
      if (m_req && entry_addr !== m_caddr) begin
        fails++; $display("FAIL R5 model entry_addr actual=%h expected=%h", entry_addr, m_caddr);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int kind, input int idx, input logic [31:0] data);
    wr_en = 1; wr_kind = 3'(kind); wr_idx = 5'(idx); wr_data = data;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic pulse(input int i);
    irq[i] = 1; cyc(1); irq[i] = 0;
  endtask

  task automatic ret();
    handler_ret = 1; cyc(1); handler_ret = 0;
  endtask

  task automatic take(input string tag, input int src, input bit tail);
    int w;
    w = 0;
    while (!entry_req && w < 12) begin cyc(1); w++; end
    chk({tag, " req"}, entry_req, 1);
    chk({tag, " src"}, entry_src, src);
    chk({tag, " addr"}, entry_addr, 32'h1000 + 16*src);
    chk({tag, " tail"}, tail_chain, tail);
    entry_ack = 1; cyc(1); entry_ack = 0;
  endtask

  task automatic no_req(input string tag, input int n);
    bit seen;
    seen = 0;
    for (int k = 0; k < n; k++) begin cyc(1); if (entry_req) seen = 1; end
    chk(tag, seen, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    cyc(3);
    chk("R1 reset req", entry_req, 0);
    chk("R1 reset tail", tail_chain, 0);
    rst_n = 1;
    cyc(1);
    chk("R1 after reset req", entry_req, 0);

    for (int i = 0; i < N; i++) begin
      wr(0, i, 200);              // R12 urgency
      wr(1, i, 1);                // R8 enable
      wr(2, i, 32'h1000 + 16*i);  // R5 handler address
    end
    wr(0, 5, 60); wr(0, 6, 30); wr(0, 7, 30);
    wr(0, 2, 100); wr(0, 3, 150); wr(0, 4, 100); wr(0, 8, 50);
    for (int k = 0; k < 9; k++) wr(0, 10 + k, 90 - 10*k);
    cyc(2);

    // R4 rising edge pends; single line
    pulse(5);
    take("R4 single", 5, 0);
    no_req("R7 req drops after ack", 3);
    ret();
    no_req("R11 idle after return", 3);

    // R2 different urgencies at once, then tail chain to the loser
    irq[1] = 1; irq[5] = 1; cyc(1); irq = '0;
    take("R2 most urgent", 5, 0);
    no_req("R3 less urgent waits", 4);
    ret();
    take("R6 tail to lower", 1, 1);
    ret();

    // R2 tie goes to lowest index
    irq[6] = 1; irq[7] = 1; cyc(1); irq = '0;
    take("R2 tie low index", 6, 0);
    ret();
    take("R6 tie chain", 7, 1);
    ret();
    cyc(2);

    // R3 preemption strict only
    pulse(2);
    take("R3 base", 2, 0);
    pulse(4);
    no_req("R3 equal never preempts", 6);
    pulse(8);
    take("R3 preempt", 8, 0);
    ret();
    no_req("R11 pop back to 100 blocks equal", 5);
    ret();
    take("R6 chain after unwind", 4, 1);
    ret();
    cyc(2);

    // R11 return while idle ignored, no spurious chain
    ret();
    pulse(5);
    take("R11 idle return no chain", 5, 0);
    ret();
    cyc(2);

    // R9 global mask
    mask_all = 1;
    pulse(5);
    no_req("R9 masked", 8);
    mask_all = 0;
    take("R9 unmask pending kept", 5, 0);
    ret();

    // R8 disable holds the flag
    wr(1, 20, 0);
    pulse(20);
    no_req("R8 disabled", 8);
    wr(1, 20, 1);
    take("R8 enable releases", 20, 0);
    ret();

    // R4 software set and clear
    wr(3, 21, 0);
    take("R4 software set", 21, 0);
    ret();
    mask_all = 1;
    wr(3, 22, 0);
    wr(4, 22, 0);
    mask_all = 0;
    no_req("R4 software clear", 6);

    // R12 reprogrammed urgency reorders
    wr(0, 9, 5);
    irq[9] = 1; irq[5] = 1; cyc(1); irq = '0;
    take("R12 new urgency wins", 9, 0);
    ret();
    take("R12 chain", 5, 1);
    ret();
    cyc(2);

    // R10 stack limit
    for (int k = 0; k < 8; k++) begin
      pulse(10 + k);
      take("R10 nest", 10 + k, 0);
    end
    pulse(18);
    no_req("R10 full holds off", 8);
    ret();
    take("R10 freed level", 18, 1);
    for (int k = 0; k < 8; k++) begin ret(); cyc(1); end
    no_req("R11 fully unwound", 4);

    done = 1;
    summary();
    $finish;
  end

endmodule